// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the software-visible registers of a seven-channel DMA controller and decides when a channel may begin a transfer. Every channel owns three 32-bit registers: a memory address, a block count and a channel control word. Two shared registers sit next to them. One holds a per-channel enable bit together with priority fields, and the other holds interrupt enables and interrupt flags.

A write to a channel's control word can launch that channel. The launch happens only when the written word has its busy bit (bit 24) set and that channel's enable bit, bit 4·n+3, is set in the shared enable register. A launch is a one-cycle strobe on that channel's start line. The strobe comes with the channel's stored address, count and control values, so the transfer engine can take them over. When the engine reports completion on the channel's done line, the busy bit in the control word is cleared. The matching interrupt flag is also raised, but only if that channel's interrupt enable is set.

The register port has no wait states. A write takes effect at the next clock edge, and read data follows the offset combinationally.

Top module: `dma_regfile`

## Requirements
- R1: After reset every register reads as zero and no start strobe is active.
- R2: Channel n (0..6) exposes its address at offset 0x80+16·n, its block count at 0x84+16·n and its control word at 0x88+16·n. Each of them stores the full 32-bit written value and reads it back.
- R3: A write to channel n's control word with bit 24 set, while bit 4·n+3 of the enable register is 1, makes start_pulse[n] high for exactly the one cycle that follows the write edge. At most one start bit is high in any cycle.
- R4: A control-word write with bit 24 clear, or with the channel's enable bit clear, stores the value but produces no start strobe.
- R5: While start_pulse[n] is high, slice n of start_addr, start_count and start_ctrl carries that channel's stored address, count and the control word just written.
- R6: The enable register at offset 0xF0 stores and returns all 32 bits.
- R7: A write to the interrupt register at offset 0xF4 loads bits 23:0 directly from the written value.
- R8: On the same write, each of bits 31:24 is cleared where the written bit is 1 and kept where the written bit is 0.
- R9: A pulse on xfer_done[n] clears bit 24 of channel n's control word and leaves its other bits unchanged.
- R10: A pulse on xfer_done[n] sets interrupt flag bit 24+n when enable bit 16+n is 1, and leaves the flag unchanged when that enable bit is 0. A flag set in the same cycle as a clearing write ends up set.
- R11: Offsets outside the mapped set, such as 0x00, 0x8C and 0xFC, read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| xfer_done | input | 7 | Per-channel completion pulse from the transfer engine |
| start_pulse | output | 7 | Per-channel one-cycle start strobe |
| start_addr | output | 224 | Stored address per channel, channel n at bits 32·n+31:32·n |
| start_count | output | 224 | Stored block count per channel, same packing |
| start_ctrl | output | 224 | Stored control word per channel, same packing |

## Verification
The assertions check the following on every cycle:
- each start strobe traces back to a qualifying control write of the previous cycle, and carries the value that was written;
- the strobes are one-hot or idle;
- a completion clears the busy bit;
- the direct low field and the write-1-to-clear upper field of the interrupt register behave as R7 and R8 require, and an enabled completion raises its flag;
- unmapped offsets read as zero.

Some behaviour only the bench scenarios can show: that a disabled or non-busy control write launches nothing, that writes to unmapped offsets leave every real register intact, that values read back across all register kinds, and that a flag set wins over a clearing write in the same cycle.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
  localparam int OFF_W        = 8;
  localparam int REG_W        = 32;
  localparam int BUSY_BIT     = 24;
  localparam int IRQ_LOW_W    = 24;
  localparam int IRQ_EN_LSB   = 16;
  localparam int IRQ_FLAG_LSB = 24;

  // upper nibble of channel 0's bank; channel n uses nibble CH_BANK0 + n
  localparam logic [3:0] CH_BANK0 = 4'h8;
  localparam logic [3:0] SUB_ADDR = 4'h0;
  localparam logic [3:0] SUB_CNT  = 4'h4;
  localparam logic [3:0] SUB_CTRL = 4'h8;
  localparam logic [OFF_W-1:0] OFF_GLOB = 8'hF0;
  localparam logic [OFF_W-1:0] OFF_IRQ  = 8'hF4;

  function automatic int chan_en_bit(input int n);
    return 4 * n + 3;
  endfunction
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 7
) (
  input  logic [OFF_W-1:0]  off,
  output logic [NUM_CH-1:0] hit_addr,
  output logic [NUM_CH-1:0] hit_cnt,
  output logic [NUM_CH-1:0] hit_ctrl,
  output logic              hit_glob,
  output logic              hit_irq
);
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic bank_hit;
    assign bank_hit    = (off[OFF_W-1:4] == 4'(int'(CH_BANK0) + n));
    assign hit_addr[n] = bank_hit && (off[3:0] == SUB_ADDR);
    assign hit_cnt[n]  = bank_hit && (off[3:0] == SUB_CNT);
    assign hit_ctrl[n] = bank_hit && (off[3:0] == SUB_CTRL);
  end

  assign hit_glob = (off == OFF_GLOB);
  assign hit_irq  = (off == OFF_IRQ);
endmodule

// File: rtl/dma_rf_channel.sv
module dma_rf_channel
  import dma_rf_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic          hit_addr,
  input  logic          hit_cnt,
  input  logic          hit_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          chan_en,
  input  logic          done,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] ctrl_q,
  output logic          start_q
);
  logic          addr_we, cnt_we, ctrl_we;
  logic [DW-1:0] ctrl_d;
  logic          start_d;

  always_comb begin
    addr_we = wr && hit_addr;
    cnt_we  = wr && hit_cnt;
    ctrl_we = (wr && hit_ctrl) || done;
    ctrl_d  = ctrl_q;
    if (wr && hit_ctrl) begin
      ctrl_d = wdata;             // a register write wins over completion
    end else if (done) begin
      ctrl_d[BUSY_BIT] = 1'b0;
    end
    start_d = wr && hit_ctrl && wdata[BUSY_BIT] && chan_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      start_q <= 1'b0;
    end else begin
      if (addr_we) addr_q <= wdata;
      if (cnt_we)  cnt_q  <= wdata;
      if (ctrl_we) ctrl_q <= ctrl_d;
      start_q <= start_d;
    end
  end
endmodule

// File: rtl/dma_rf_irq.sv
module dma_rf_irq
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int DW     = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DW-1:0]     wdata,
  input  logic [NUM_CH-1:0] done,
  output logic [DW-1:0]     irq_q
);
  logic [DW-1:0] irq_d;
  logic          irq_we;

  always_comb begin
    irq_we = wr_hit || (|done);
    irq_d  = irq_q;
    if (wr_hit) begin
      irq_d[IRQ_LOW_W-1:0]  = wdata[IRQ_LOW_W-1:0];
      irq_d[DW-1:IRQ_LOW_W] = irq_q[DW-1:IRQ_LOW_W] & ~wdata[DW-1:IRQ_LOW_W];
    end
    // flag raising comes last so it overrides a simultaneous clear
    for (int n = 0; n < NUM_CH; n++) begin
      if (done[n] && irq_q[IRQ_EN_LSB+n]) irq_d[IRQ_FLAG_LSB+n] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else if (irq_we) begin
      irq_q <= irq_d;
    end
  end
endmodule

// File: rtl/dma_regfile.sv
module dma_regfile
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int DW     = REG_W,
  localparam int VW    = NUM_CH * DW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic [NUM_CH-1:0] start_pulse,
  output logic [VW-1:0]     start_addr,
  output logic [VW-1:0]     start_count,
  output logic [VW-1:0]     start_ctrl
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic [NUM_CH-1:0] hit_addr, hit_cnt, hit_ctrl;
  logic              hit_glob, hit_irq;
  logic [DW-1:0]     glob_q;
  logic [DW-1:0]     irq_q;
  logic [NUM_CH-1:0] chan_en;
  logic [DW-1:0]     ch_addr [NUM_CH];
  logic [DW-1:0]     ch_cnt  [NUM_CH];
  logic [DW-1:0]     ch_ctrl [NUM_CH];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  dma_rf_decode #(.NUM_CH(NUM_CH)) i_decode (
    .off      (reg_addr),
    .hit_addr (hit_addr),
    .hit_cnt  (hit_cnt),
    .hit_ctrl (hit_ctrl),
    .hit_glob (hit_glob),
    .hit_irq  (hit_irq)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)             glob_q <= '0;
    else if (reg_wr && hit_glob) glob_q <= reg_wdata;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    assign chan_en[n] = glob_q[chan_en_bit(n)];

    dma_rf_channel #(.DW(DW)) i_channel (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .wr       (reg_wr),
      .hit_addr (hit_addr[n]),
      .hit_cnt  (hit_cnt[n]),
      .hit_ctrl (hit_ctrl[n]),
      .wdata    (reg_wdata),
      .chan_en  (chan_en[n]),
      .done     (xfer_done[n]),
      .addr_q   (ch_addr[n]),
      .cnt_q    (ch_cnt[n]),
      .ctrl_q   (ch_ctrl[n]),
      .start_q  (start_pulse[n])
    );

    assign start_addr[n*DW +: DW]  = ch_addr[n];
    assign start_count[n*DW +: DW] = ch_cnt[n];
    assign start_ctrl[n*DW +: DW]  = ch_ctrl[n];
  end

  dma_rf_irq #(.NUM_CH(NUM_CH), .DW(DW)) i_irq (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .wr_hit (reg_wr && hit_irq),
    .wdata  (reg_wdata),
    .done   (xfer_done),
    .irq_q  (irq_q)
  );

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (hit_addr[n]) reg_rdata = ch_addr[n];
      if (hit_cnt[n])  reg_rdata = ch_cnt[n];
      if (hit_ctrl[n]) reg_rdata = ch_ctrl[n];
    end
    if (hit_glob) reg_rdata = glob_q;
    if (hit_irq)  reg_rdata = irq_q;
  end
endmodule

// File: rtl/dma_regfile_chk.sv
module dma_regfile_chk
  import dma_rf_pkg::*;
#(
  parameter int NUM_CH = 7,
  parameter int DW     = REG_W
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr,
  input logic [OFF_W-1:0]     reg_addr,
  input logic [DW-1:0]        reg_wdata,
  input logic [DW-1:0]        reg_rdata,
  input logic [NUM_CH-1:0]    xfer_done,
  input logic [NUM_CH-1:0]    start_pulse,
  input logic [NUM_CH*DW-1:0] start_ctrl,
  input logic [NUM_CH-1:0]    chan_en,
  input logic [DW-1:0]        irq_q
);
  // R3: strobes never overlap
  assert_start_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_pulse));

  // R7: direct low field of the interrupt register
  assert_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_IRQ)
    |=> irq_q[IRQ_LOW_W-1:0] == $past(reg_wdata[IRQ_LOW_W-1:0]));

  // R8: written ones clear flags when no completion competes
  assert_irq_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_IRQ && xfer_done == '0)
    |=> (irq_q[DW-1:IRQ_LOW_W] & $past(reg_wdata[DW-1:IRQ_LOW_W])) == '0);

  // R11: unmapped offsets read as zero
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[3:0] == 4'hC || reg_addr < 8'h80) |-> reg_rdata == '0);

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    localparam logic [OFF_W-1:0] CTRL_OFF = OFF_W'(8'h88 + 16 * n);

    // R3: a strobe needs a qualifying control write one cycle earlier
    assert_start_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[n]
      |-> $past(reg_wr && reg_addr == CTRL_OFF && reg_wdata[BUSY_BIT] && chan_en[n]));

    // R5: strobe carries the written control word
    assert_start_value_R5: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[n] |-> start_ctrl[n*DW +: DW] == $past(reg_wdata));

    // R9: completion clears busy unless the same cycle rewrites the word
    assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done[n] && !(reg_wr && reg_addr == CTRL_OFF))
      |=> !start_ctrl[n*DW + BUSY_BIT]);

    // R10: enabled completion raises its flag
    assert_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done[n] && irq_q[IRQ_EN_LSB+n]) |=> irq_q[IRQ_FLAG_LSB+n]);
  end
endmodule

bind dma_regfile dma_regfile_chk #(.NUM_CH(NUM_CH), .DW(DW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .xfer_done   (xfer_done),
  .start_pulse (start_pulse),
  .start_ctrl  (start_ctrl),
  .chan_en     (chan_en),
  .irq_q       (irq_q)
);

// File: tb/test_dma_regfile.sv
module test_dma_regfile;
  localparam int NCH = 7;
  localparam int DW  = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic             reg_wr = 1'b0;
  logic [7:0]       reg_addr = '0;
  logic [DW-1:0]    reg_wdata = '0;
  logic [DW-1:0]    reg_rdata;
  logic [NCH-1:0]   xfer_done = '0;
  logic [NCH-1:0]   start_pulse;
  logic [NCH*DW-1:0] start_addr, start_count, start_ctrl;

  dma_regfile i_dma_regfile (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .start_pulse(start_pulse), .start_addr(start_addr),
    .start_count(start_count), .start_ctrl(start_ctrl)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit reported = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int at; int ch; logic [DW-1:0] a; logic [DW-1:0] c; logic [DW-1:0] k; } start_item_t;
  typedef struct { logic [DW-1:0] exp; string tag; } rd_item_t;
  start_item_t sq[$];
  rd_item_t    rq[$];
  logic        rd_chk = 1'b0;

  // bench model of stored values, updated from the requirements
  logic [DW-1:0] m_addr [NCH];
  logic [DW-1:0] m_cnt  [NCH];
  logic [DW-1:0] m_glob;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: pops expected reads and starts as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      rd_item_t       ri;
      start_item_t    si;
      logic [NCH-1:0] ev;
      if (rd_chk && rq.size() > 0) begin
        ri = rq.pop_front();
        check(reg_rdata === ri.exp, ri.tag, reg_rdata, ri.exp);
      end
      ev = '0;
      if (sq.size() > 0 && sq[0].at == cyc) begin
        si = sq.pop_front();
        ev[si.ch] = 1'b1;
        check(start_addr[si.ch*DW +: DW] === si.a, "R5 start address", start_addr[si.ch*DW +: DW], si.a);
        check(start_count[si.ch*DW +: DW] === si.c, "R5 start count", start_count[si.ch*DW +: DW], si.c);
        check(start_ctrl[si.ch*DW +: DW] === si.k, "R5 start control", start_ctrl[si.ch*DW +: DW], si.k);
      end
      if (start_pulse !== '0 || ev != '0)
        check(start_pulse === ev, "R3/R4 start strobe", DW'(start_pulse), DW'(ev));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [DW-1:0] d, input logic [NCH-1:0] dn = '0);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; xfer_done = dn;
    for (int n = 0; n < NCH; n++) begin
      if (a == 8'(8'h80 + 16 * n)) m_addr[n] = d;
      if (a == 8'(8'h84 + 16 * n)) m_cnt[n] = d;
      if (a == 8'(8'h88 + 16 * n) && d[24] && m_glob[4*n+3]) begin
        start_item_t it;
        it.at = cyc + 1; it.ch = n; it.a = m_addr[n]; it.c = m_cnt[n]; it.k = d;
        sq.push_back(it);
      end
    end
    if (a == 8'hF0) m_glob = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; xfer_done = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [DW-1:0] e, input string tag);
    rd_item_t it;
    @(posedge clk); #1;
    reg_addr = a; it.exp = e; it.tag = tag;
    rq.push_back(it);
    rd_chk = 1'b1;
    @(negedge clk); #1;
    rd_chk = 1'b0;
  endtask

  task automatic done_pulse(input logic [NCH-1:0] dn);
    @(posedge clk); #1;
    xfer_done = dn;
    @(posedge clk); #1;
    xfer_done = '0;
  endtask

  initial begin
    #(20 * 100000);
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    checks++; errors++;
    report();
  end

  initial begin
    for (int n = 0; n < NCH; n++) begin m_addr[n] = '0; m_cnt[n] = '0; end
    m_glob = '0;
    repeat (3) @(posedge clk);
    #1;
    check(start_pulse === '0, "R1 no strobe in reset", DW'(start_pulse), '0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values
    rd(8'h88, 32'h0, "R1 ch0 control reset");
    rd(8'hF0, 32'h0, "R1 enable reset");
    rd(8'hF4, 32'h0, "R1 interrupt reset");

    // R2: channel storage
    wr(8'hA0, 32'h0001_2340);
    wr(8'hA4, 32'h0010_0008);
    rd(8'hA0, 32'h0001_2340, "R2 ch2 address");
    rd(8'hA4, 32'h0010_0008, "R2 ch2 count");

    // R4: busy set, channel disabled
    wr(8'hA8, 32'h0100_0201);
    rd(8'hA8, 32'h0100_0201, "R4 ch2 control stored without start");

    // R6: enable register; bits 3,7,...,27 enable ch0..ch6
    wr(8'hF0, 32'h0888_8888);
    rd(8'hF0, 32'h0888_8888, "R6 enable readback");

    // R3 and R5: qualifying write starts ch2
    wr(8'hA8, 32'h0100_0201);
    // R4: busy bit clear, no start
    wr(8'hA8, 32'h0000_0201);
    rd(8'hA8, 32'h0000_0201, "R4 ch2 control without busy");

    // R3: ch6 uses enable bit 27
    wr(8'hE0, 32'h00AB_CDEF);
    wr(8'hE4, 32'h0000_0040);
    wr(8'hE8, 32'h0100_0007);
    wr(8'hF0, 32'h0088_8888);
    wr(8'hE8, 32'h0100_0003);
    rd(8'hE8, 32'h0100_0003, "R4 ch6 control stored while disabled");

    // R7: direct low field, enables for ch0..ch6 at bits 16..22
    wr(8'hF4, 32'h007F_00AB);
    rd(8'hF4, 32'h007F_00AB, "R7 interrupt low field");

    // R9 and R10: start ch2 then complete it
    wr(8'hA8, 32'h0100_0201);
    done_pulse(7'b000_0100);
    rd(8'hA8, 32'h0000_0201, "R9 busy cleared by done");
    rd(8'hF4, 32'h047F_00AB, "R10 ch2 flag bit 26 set");
    done_pulse(7'b010_0000);
    rd(8'hF4, 32'h247F_00AB, "R10 ch5 flag bit 29 set");

    // R8: write one clears bit 26, bit 29 kept
    wr(8'hF4, 32'h0400_1234);
    rd(8'hF4, 32'h2000_1234, "R8 write one to clear");
    // R10: enable bit 16 now clear, done on ch0 sets nothing
    done_pulse(7'b000_0001);
    rd(8'hF4, 32'h2000_1234, "R10 disabled flag not set");

    // R10: set wins over a clearing write in the same cycle
    wr(8'hF4, 32'h0001_0000);
    rd(8'hF4, 32'h2001_0000, "R8 zero upper bits keep flags");
    wr(8'hF4, 32'h0101_0000, 7'b000_0001);
    rd(8'hF4, 32'h2101_0000, "R10 set beats clear");

    // R11: unmapped offsets
    wr(8'h8C, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h8C, 32'h0, "R11 offset 0x8C reads zero");
    rd(8'hFC, 32'h0, "R11 offset 0xFC reads zero");
    rd(8'h00, 32'h0, "R11 offset 0x00 reads zero");
    rd(8'h80, 32'h0, "R11 ch0 address untouched");
    rd(8'h88, 32'h0, "R11 ch0 control untouched");
    rd(8'hF0, 32'h0088_8888, "R11 enable untouched");
    rd(8'hF4, 32'h2101_0000, "R11 interrupt untouched");

    repeat (4) @(posedge clk);
    #1;
    check(sq.size() == 0, "R3 all expected starts seen", DW'(sq.size()), '0);
    report();
  end
endmodule